// File: doc/BRIEF.md
# Programmable Bypassable Clock Divider

This block derives an output clock from an input clock under the control of one 8-bit configuration register. A 4-bit ratio code picks division by one to eight, or a bypass in which the input clock is routed unchanged to the output. Odd ratios give the closest duty cycle the input edges allow. Divide-by-one still goes through the divider: a rising-edge flop and a falling-edge flop together rebuild the input waveform.

The register is written on the rising edge of the input clock. A self-holding reset bit in the register puts the divider back to its default bypass state. It stays there until software clears the bit, and the write that clears it also loads the new ratio. A ratio written while the divider runs is stored and can be read back, but it does not change the output until the next reset. An asynchronous global reset clears the register and the divider only while a separate enable input is high.

Top module: `clkdiv_top`

## Requirements
- R1: While gRstN is low and gRstEn is high, the register reads back 0x00 and clkOut follows clkIn (bypass). These remain after gRstN rises.
- R2: Codes 1 to 8 in bits [3:0] set the ratio N. clkOut then rises once every N clkIn cycles, on clkIn rising edges.
- R3: For even N, clkOut is high for N/2 input cycles and low for N/2.
- R4: For odd N of 3 or more, clkOut is high for (N+1)/2 input cycles and low for (N-1)/2.
- R5: With N = 1, clkOut is rebuilt by the divider. It is high in the high half of every clkIn cycle and low in the low half, starting with the first clkIn cycle after release.
- R6: Codes 9 to 15 divide by the code modulo 8, so 9 divides by 1. Code 8 divides by 8.
- R7: Bits [6:4] have no effect on the output and read back as 0.
- R8: A write with bit 7 set makes the register read 0x80 (bit 7 set, code 0), and clkOut follows clkIn. This state holds until a write with bit 7 clear.
- R9: A write with bit 7 clear while bit 7 is set releases the divider with the code written. clkOut first rises at the first clkIn rising edge after the releasing write edge.
- R10: A write with bit 7 clear while bit 7 is already clear updates the readback code but leaves the running ratio unchanged.
- R11: With gRstEn low, a low pulse on gRstN changes neither the register nor the output waveform.
- R12: Register writes take effect on the clkIn rising edge at which cfgWr is high. The readback shows bit 7 and bits [3:0] as last written, with the code forced to 0 when bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock |
| gRstN | input | 1 | Asynchronous global reset, active low |
| gRstEn | input | 1 | Lets gRstN reset the block when high |
| cfgWr | input | 1 | Register write strobe, sampled on clkIn rising edge |
| cfgWdata | input | 8 | Register write data |
| clkOut | output | 1 | Divided, rebuilt or bypassed clock |
| cfgRdata | output | 8 | Register readback |

## Verification
The bench builds the block with its default parameters: a 4-bit code in an 8-bit register with the reset flag at bit 7. This makes every code from 0 to 15 reachable, including the folded codes above 8. Those defaults put every ratio from one to eight within reach, so even and odd duty shapes, the rebuilt divide-by-one clock and the maximum ratio are each checked edge by edge from the releasing write. The masked global reset and a ratio write made while running are checked by measuring the output period across the event.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W = 4;
  localparam int DATA_W = 8;
  localparam int RST_POS = 7;

  // control to datapath: reload strobe and the ratio code to take
  typedef struct packed {
    logic              load;
    logic [CODE_W-1:0] code;
  } ctlStb_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DataW  = DATA_W,
  parameter int CodeW  = CODE_W,
  parameter int RstPos = RST_POS
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [DataW-1:0] cfgWdata,
  output logic [DataW-1:0] cfgRdata,
  output ctlStb_t          stb
);
  logic [CodeW-1:0] codeQ;
  logic             rstBitQ;
  logic             wrRst;
  logic             wrRun;

  assign wrRst = cfgWr & cfgWdata[RstPos];
  assign wrRun = cfgWr & ~cfgWdata[RstPos];

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= '0;
      rstBitQ <= 1'b0;
    end else if (wrRst) begin
      codeQ   <= '0;
      rstBitQ <= 1'b1;
    end else if (wrRun) begin
      codeQ   <= cfgWdata[CodeW-1:0];
      rstBitQ <= 1'b0;
    end
  end

  // divider reloads while the local reset is held, and on the edge that
  // either sets it or releases it
  always_comb begin
    stb.load = rstBitQ | wrRst;
    stb.code = (rstBitQ && wrRun) ? cfgWdata[CodeW-1:0] : '0;
  end

  always_comb begin
    cfgRdata              = '0;
    cfgRdata[CodeW-1:0]   = codeQ;
    cfgRdata[RstPos]      = rstBitQ;
  end
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
#(
  parameter int CodeW = CODE_W
) (
  input  logic    clkIn,
  input  logic    rstN,
  input  ctlStb_t stb,
  output logic    divQ,
  output logic    regenClk,
  output logic    bypassSel,
  output logic    unitSel
);
  localparam int FoldW = CodeW - 1;
  localparam int MaxRatio = 1 << FoldW;

  logic [CodeW-1:0] runCode;
  logic [FoldW-1:0] cnt;
  logic [FoldW-1:0] nextCnt;
  logic [FoldW-1:0] lastIdx;
  logic [CodeW-1:0] hiCnt;
  logic [CodeW-1:0] ratio;
  logic             posT;
  logic             negT;

  // fold the code modulo MaxRatio; a folded zero means the largest ratio
  function automatic logic [CodeW-1:0] foldRatio(input logic [CodeW-1:0] c);
    logic [FoldW-1:0] f;
    f = c[FoldW-1:0];
    return (f == '0) ? CodeW'(MaxRatio) : CodeW'(f);
  endfunction

  always_comb begin
    ratio   = foldRatio(runCode);
    lastIdx = FoldW'(ratio - 1'b1);
    hiCnt   = (ratio + 1'b1) >> 1;
    nextCnt = (cnt == lastIdx) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      runCode <= '0;
      cnt     <= '0;
      divQ    <= 1'b0;
      posT    <= 1'b0;
    end else if (stb.load) begin
      runCode <= stb.code;
      cnt     <= FoldW'(foldRatio(stb.code) - 1'b1);
      divQ    <= 1'b0;
      posT    <= 1'b0;
    end else begin
      cnt     <= nextCnt;
      divQ    <= (CodeW'(nextCnt) < hiCnt);
      posT    <= ~posT;
    end
  end

  // falling-edge follower: posT ^ negT is high from rise to fall of clkIn
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) negT <= 1'b0;
    else       negT <= posT;
  end

  assign regenClk  = posT ^ negT;
  assign bypassSel = (runCode == '0);
  assign unitSel   = (ratio == CodeW'(1));
endmodule

// File: rtl/clkdiv_outmux.sv
module clkdiv_outmux (
  input  logic clkIn,
  input  logic divQ,
  input  logic regenClk,
  input  logic bypassSel,
  input  logic unitSel,
  output logic clkOut
);
  always_comb begin
    if (bypassSel)    clkOut = clkIn;
    else if (unitSel) clkOut = regenClk;
    else              clkOut = divQ;
  end
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int DataW  = DATA_W,
  parameter int CodeW  = CODE_W,
  parameter int RstPos = RST_POS
) (
  input  logic             clkIn,
  input  logic             gRstN,
  input  logic             gRstEn,
  input  logic             cfgWr,
  input  logic [DataW-1:0] cfgWdata,
  output logic             clkOut,
  output logic [DataW-1:0] cfgRdata
);
  logic    rstN;
  ctlStb_t stb;
  logic    divQ;
  logic    regenClk;
  logic    bypassSel;
  logic    unitSel;

  assign rstN = gRstN | ~gRstEn;

  clkdiv_ctrl #(.DataW(DataW), .CodeW(CodeW), .RstPos(RstPos)) uCtrl (
    .clkIn(clkIn), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .stb(stb)
  );

  clkdiv_dp #(.CodeW(CodeW)) uDp (
    .clkIn(clkIn), .rstN(rstN), .stb(stb), .divQ(divQ),
    .regenClk(regenClk), .bypassSel(bypassSel), .unitSel(unitSel)
  );

  clkdiv_outmux uMux (
    .clkIn(clkIn), .divQ(divQ), .regenClk(regenClk),
    .bypassSel(bypassSel), .unitSel(unitSel), .clkOut(clkOut)
  );
endmodule

// File: rtl/clkdiv_check.sv
module clkdiv_check
  import clkdiv_pkg::*;
#(
  parameter int DataW  = DATA_W,
  parameter int RstPos = RST_POS
) (
  input logic             clkIn,
  input logic             rstN,
  input logic             cfgWr,
  input logic [DataW-1:0] cfgWdata,
  input logic [DataW-1:0] cfgRdata,
  input ctlStb_t          stb,
  input logic             divQ,
  input logic             bypassSel
);
  p_rsv_zero_r7: assert property (@(posedge clkIn) disable iff (!rstN)
    cfgRdata[6:4] == 3'b000);

  p_lrst_set_r8: assert property (@(posedge clkIn) disable iff (!rstN)
    (cfgWr && cfgWdata[RstPos]) |=> (cfgRdata[RstPos] && cfgRdata[3:0] == 4'd0));

  p_lrst_bypass_r8: assert property (@(posedge clkIn) disable iff (!rstN)
    cfgRdata[RstPos] |-> bypassSel);

  p_load_low_r9: assert property (@(posedge clkIn) disable iff (!rstN)
    stb.load |=> !divQ);

  p_run_write_r10: assert property (@(posedge clkIn) disable iff (!rstN)
    (!cfgRdata[RstPos] && cfgWr && !cfgWdata[RstPos]) |=> $stable(bypassSel));

  p_readback_r12: assert property (@(posedge clkIn) disable iff (!rstN)
    (cfgWr && !cfgWdata[RstPos]) |=> (cfgRdata[3:0] == $past(cfgWdata[3:0])));
endmodule

bind clkdiv_top clkdiv_check #(.DataW(DataW), .RstPos(RstPos)) uChk (
  .clkIn(clkIn), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
  .cfgRdata(cfgRdata), .stb(stb), .divQ(divQ), .bypassSel(bypassSel)
);

// File: tb/clkdiv_top_test.sv
`timescale 1ns/1ps
module clkdiv_top_test;
  logic       clkIn = 1'b0;
  logic       gRstN = 1'b0;
  logic       gRstEn = 1'b1;
  logic       cfgWr = 1'b0;
  logic [7:0] cfgWdata = 8'h00;
  logic       clkOut;
  logic [7:0] cfgRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clkIn = ~clkIn;

  clkdiv_top uut (
    .clkIn(clkIn), .gRstN(gRstN), .gRstEn(gRstEn), .cfgWr(cfgWr),
    .cfgWdata(cfgWdata), .clkOut(clkOut), .cfgRdata(cfgRdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // writes land on the rising edge between the two falling edges
  task automatic writeReg(input logic [7:0] d);
    @(negedge clkIn);
    cfgWr = 1'b1;
    cfgWdata = d;
    @(negedge clkIn);
    cfgWr = 1'b0;
  endtask

  task automatic checkBypass(input string tag, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(posedge clkIn); #1;
      chk({tag, " bypass high"}, clkOut, 1);
      #2;
      chk({tag, " bypass low"}, clkOut, 0);
    end
  endtask

  // edge-by-edge shape after a releasing write; call right after writeReg
  task automatic checkShape(input string tag, input int n);
    int hi = (n + 1) / 2;
    for (int k = 1; k <= 2 * n; k++) begin
      int e = (((k - 1) % n) < hi) ? 1 : 0;
      @(posedge clkIn); #1;
      chk({tag, " high half"}, clkOut, e);
      #2;
      chk({tag, " low half"}, clkOut, (n == 1) ? 0 : e);
    end
  endtask

  task automatic checkPeriod(input string tag, input int n);
    int prev = 1;
    int gap = 0;
    bit armed = 0;
    bit got = 0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(posedge clkIn); #1;
      if (armed) gap++;
      if (clkOut && !prev) begin
        if (armed) got = 1;
        else armed = 1;
      end
      prev = clkOut;
    end
    chk({tag, " period"}, gap, n);
  endtask

  task automatic startRatio(input logic [7:0] code);
    writeReg(8'h80);
    writeReg(code);
  endtask

  task automatic t_reset;
    #1; chk("R1 readback in reset", cfgRdata, 8'h00);
    repeat (2) @(negedge clkIn);
    gRstN = 1'b1;
    checkBypass("R1", 3);
    chk("R1 readback after reset", cfgRdata, 8'h00);
  endtask

  task automatic t_ratios;
    for (int n = 2; n <= 8; n++) begin
      startRatio(8'(n));
      chk("R12 readback", cfgRdata, n);
      checkShape((n % 2 == 0) ? "R2 R3 even" : "R2 R4 odd", n);
      checkPeriod("R2", n);
    end
    startRatio(8'h01);
    checkShape("R5 unit", 1);
    checkShape("R5 unit repeat", 1);
  endtask

  task automatic t_fold;
    startRatio(8'h09); checkShape("R6 code9", 1);
    startRatio(8'h0C); checkShape("R6 code12", 4);
    startRatio(8'h0F); checkShape("R6 code15", 7);
    chk("R6 readback", cfgRdata, 8'h0F);
  endtask

  task automatic t_reserved;
    startRatio(8'h73);
    chk("R7 readback", cfgRdata, 8'h03);
    checkShape("R7 shape", 3);
  endtask

  task automatic t_local;
    startRatio(8'h06);
    writeReg(8'h85);
    chk("R8 readback", cfgRdata, 8'h80);
    checkBypass("R8", 10);
    chk("R8 still held", cfgRdata, 8'h80);
    writeReg(8'h05);
    chk("R9 readback", cfgRdata, 8'h05);
    checkShape("R9 release", 5);
  endtask

  task automatic t_runWrite;
    startRatio(8'h04);
    checkPeriod("R10 before", 4);
    writeReg(8'h02);
    chk("R10 readback", cfgRdata, 8'h02);
    checkPeriod("R10 after", 4);
    startRatio(8'h02);
    checkShape("R10 after reset", 2);
  endtask

  task automatic t_maskGlobal;
    startRatio(8'h03);
    gRstEn = 1'b0;
    gRstN  = 1'b0;
    checkShape("R11 masked", 3);
    gRstN  = 1'b1;
    gRstEn = 1'b1;
    chk("R11 readback", cfgRdata, 8'h03);
    checkPeriod("R11 period", 3);
  endtask

  task automatic t_global;
    startRatio(8'h06);
    @(negedge clkIn);
    gRstN = 1'b0;
    #1; chk("R1 global readback", cfgRdata, 8'h00);
    @(negedge clkIn);
    gRstN = 1'b1;
    checkBypass("R1 global", 3);
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_fold();
    t_reserved();
    t_local();
    t_runWrite();
    t_maskGlobal();
    t_global();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule